// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller turns single-cycle requests from an internal port into timed accesses on an external asynchronous byte-wide SRAM. The external space holds 64K bytes, so every access carries a full 16-bit address. The upper address byte always has dedicated output pins. The low byte takes one of two routes, and a mode input picks the route for each access.

In multiplexed mode, the low address byte and the data byte share one 8-bit bus. Each access begins with an address phase. In that phase an address-latch-enable strobe is high and the shared bus carries the low address byte, so an external transparent latch passes it through. When the strobe falls, the latch holds that byte, and the shared bus is then free to carry data around an active-low read or write strobe. In non-multiplexed mode there is no address phase. The low address byte goes out on its own pins, and the shared bus carries data only.

The shared bus is presented as separate output, output-enable and input vectors, which the pad ring combines. Phase lengths are parameters given in clock cycles: the latch-enable phase (ALE_CYC), the strobe pulse (STB_CYC) and the hold phase (HOLD_CYC). Each is at least one cycle. One access lasts ALE_CYC+1+STB_CYC+HOLD_CYC cycles in multiplexed mode and 1+STB_CYC+HOLD_CYC cycles in non-multiplexed mode. A one-cycle done pulse follows each access.

Top module: `xmem_mux_ctrl`

## Requirements
- R1: The controller samples `nonmux_sel` in the cycle it accepts a request. 0 selects multiplexed mode and 1 selects non-multiplexed mode. The chosen mode holds for that whole access, whatever the input does later.
- R2: `addr_hi` carries address bits 15:8 in every cycle of an access, starting the cycle after acceptance. It reads zero while idle.
- R3: In multiplexed mode, `ale` is high for exactly ALE_CYC cycles, starting the cycle after acceptance. During those cycles `ad_oe` is 1 and `ad_out` carries address bits 7:0.
- R4: During a read, `ad_oe` is 0 from the first cycle after the address phase until the end of the access. Whenever `ad_oe` is 0, `ad_out` reads zero.
- R5: During a write, `ad_oe` is 1 and `ad_out` carries the write data from the setup cycle through the last hold cycle. The data is therefore valid one cycle before `wr_n` falls and for HOLD_CYC cycles after it rises.
- R6: The strobes `rd_n` and `wr_n` are active low. One setup cycle follows the address phase (or acceptance, in non-multiplexed mode), and then the strobe for the operation is low for exactly STB_CYC cycles. The two strobes are never low at the same time.
- R7: On a read, the controller samples `ad_in` at the clock edge that ends the last strobe cycle, and `rdata` shows that byte from the next cycle. `rdata` holds its value until the next read samples again.
- R8: `done` is high for exactly one cycle, the cycle after the last hold cycle.
- R9: The controller accepts a request only while idle, and the cycle in which `done` is high counts as idle. A request raised during an access has no effect on the access in progress.
- R10: In non-multiplexed mode, `ale` stays low. `addr_lo` carries address bits 7:0 for the whole access, and `ad_out`/`ad_oe` carry only write data, under the R5 timing. In multiplexed mode, `addr_lo` reads zero.
- R11: While reset is high and after it is released, before the first request, the outputs are idle: `ale` 0, `ad_oe` 0, `ad_out` 0, both strobes 1, `addr_hi`/`addr_lo` 0, `done` 0 and `rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled while idle |
| we | input | 1 | 1 = write, 0 = read |
| nonmux_sel | input | 1 | Mode for this access: 1 = non-multiplexed |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Data captured by the most recent read |
| done | output | 1 | One-cycle completion pulse |
| addr_hi | output | 8 | External address bits 15:8 |
| addr_lo | output | 8 | External address bits 7:0, non-multiplexed mode only |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench writes and reads back in multiplexed mode, in non-multiplexed mode, and across the two modes. A byte written in one mode and read in the other shows whether the latched low byte and the direct low byte address the same location. Reads of never-written addresses return an address-derived pattern, which exposes a wrong capture cycle or wrong address bits. Junk requests raised in the middle of an access show whether a busy request is ignored. A request held high without a break shows whether the done cycle accepts the next access.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STRB,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic              we;
    logic              nonmux;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } op_t;
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ALE_CYC  = 2,
  parameter int STB_CYC  = 3,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic              nonmux_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output phase_e            phase_d,
  output op_t               op_d,
  output logic              fin_d,
  output logic              cap_en
);
  localparam int MAX_AS = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int MAXC   = (MAX_AS > HOLD_CYC) ? MAX_AS : HOLD_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  phase_e        phase_q;
  op_t           op_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // next phase, remaining-cycle counter and latched request
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    fin_d   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          op_d.we     = we;
          op_d.nonmux = nonmux_sel;
          op_d.addr   = addr;
          op_d.wdata  = wdata;
          if (nonmux_sel) begin
            phase_d = PH_SETUP;
            cnt_d   = '0;
          end else begin
            phase_d = PH_ALE;
            cnt_d   = CW'(ALE_CYC - 1);
          end
        end
      end
      PH_ALE: begin
        if (cnt_q == '0) phase_d = PH_SETUP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_SETUP: begin
        phase_d = PH_STRB;
        cnt_d   = CW'(STB_CYC - 1);
      end
      PH_STRB: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          fin_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // last strobe cycle of a read: sample the bus at its closing edge
  assign cap_en = (phase_q == PH_STRB) && (cnt_q == '0) && !op_q.we;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
    end
  end
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_d,
  input  op_t               op_d,
  input  logic              fin_d,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done
);
  logic              act, in_ale, in_data, in_strb;
  logic [HI_W-1:0]   hi_n;
  logic [DATA_W-1:0] lo_n, ad_n;
  logic              oe_n;

  always_comb begin
    act     = (phase_d != PH_IDLE);
    in_ale  = (phase_d == PH_ALE);
    in_data = (phase_d == PH_SETUP) || (phase_d == PH_STRB) || (phase_d == PH_HOLD);
    in_strb = (phase_d == PH_STRB);
    hi_n    = act ? op_d.addr[ADDR_W-1:DATA_W] : '0;
    lo_n    = (act && op_d.nonmux) ? op_d.addr[DATA_W-1:0] : '0;
    oe_n    = in_ale || (in_data && op_d.we);
    if (in_ale)                  ad_n = op_d.addr[DATA_W-1:0];
    else if (in_data && op_d.we) ad_n = op_d.wdata;
    else                         ad_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi <= '0;
      addr_lo <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      addr_hi <= hi_n;
      addr_lo <= lo_n;
      ad_out  <= ad_n;
      ad_oe   <= oe_n;
      ale     <= in_ale;
      rd_n    <= !(in_strb && !op_d.we);
      wr_n    <= !(in_strb && op_d.we);
      done    <= fin_d;
    end
  end
endmodule

// File: rtl/xmem_rcap.sv
module xmem_rcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cap_en) rdata <= ad_in;
  end
endmodule

// File: rtl/xmem_mux_ctrl.sv
module xmem_mux_ctrl
  import xmem_pkg::*;
#(
  parameter int ALE_CYC  = 2,
  parameter int STB_CYC  = 3,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic              nonmux_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  phase_e phase_d;
  op_t    op_d;
  logic   fin_d, cap_en;

  xmem_seq #(
    .ALE_CYC (ALE_CYC),
    .STB_CYC (STB_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .we        (we),
    .nonmux_sel(nonmux_sel),
    .addr      (addr),
    .wdata     (wdata),
    .phase_d   (phase_d),
    .op_d      (op_d),
    .fin_d     (fin_d),
    .cap_en    (cap_en)
  );

  xmem_pins u_pins (
    .clk    (clk),
    .rst    (rst),
    .phase_d(phase_d),
    .op_d   (op_d),
    .fin_d  (fin_d),
    .addr_hi(addr_hi),
    .addr_lo(addr_lo),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .done   (done)
  );

  xmem_rcap #(.DW(DATA_W)) u_rcap (
    .clk   (clk),
    .rst   (rst),
    .cap_en(cap_en),
    .ad_in (ad_in),
    .rdata (rdata)
  );
endmodule

// File: rtl/xmem_mux_ctrl_chk.sv
module xmem_mux_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic [7:0] ad_out,
  input logic       ad_oe,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));

  // R3
  ale_drive_chk: assert property (@(posedge clk) disable iff (rst) ale |-> ad_oe);

  // R4
  rd_float_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> (!ad_oe && !ale));

  // R5
  wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> ($past(ad_oe) && $stable(ad_out)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

bind xmem_mux_ctrl xmem_mux_ctrl_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .done  (done),
  .ad_out(ad_out),
  .ad_oe (ad_oe),
  .ale   (ale),
  .rd_n  (rd_n),
  .wr_n  (wr_n)
);

// File: tb/xmem_mux_ctrl_test.sv
`timescale 1ns/1ps
module xmem_mux_ctrl_test;
  localparam int ALE_N  = 2;
  localparam int STB_N  = 3;
  localparam int HOLD_N = 1;

  logic        clk = 1'b0;
  logic        rst, req, we, nonmux_sel;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata, addr_hi, addr_lo, ad_out, ad_in;
  logic        done, ad_oe, ale, rd_n, wr_n;

  always #2.5 clk = ~clk;

  xmem_mux_ctrl #(.ALE_CYC(ALE_N), .STB_CYC(STB_N), .HOLD_CYC(HOLD_N)) uut (
    .clk(clk), .rst(rst), .req(req), .we(we), .nonmux_sel(nonmux_sel),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  int vecs = 0;
  int errs = 0;
  bit chk_on = 0;

  // reference model state
  bit          m_busy = 0, m_done = 0, m_we = 0, m_nm = 0;
  int          m_t = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rdata = '0;
  logic [7:0]  refmem [int];

  // external SRAM model
  logic [7:0]  sram [int];
  logic [7:0]  latch_lo = '0;

  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int alen(bit nm);
    return nm ? 0 : ALE_N;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy  = 0;
      m_done  = 0;
      m_rdata = '0;
    end else if (m_busy) begin
      if (!m_we && m_t == alen(m_nm) + STB_N)
        m_rdata = refmem.exists(int'(m_addr)) ? refmem[int'(m_addr)] : dflt(m_addr);
      m_t++;
      if (m_t == alen(m_nm) + 1 + STB_N + HOLD_N) begin
        m_busy = 0;
        m_done = 1;
      end
    end else begin
      m_done = 0;
      if (req) begin
        m_busy = 1;
        m_t    = 0;
        m_we   = we;
        m_nm   = nonmux_sel;
        m_addr = addr;
        m_wd   = wdata;
        if (we) refmem[int'(addr)] = wdata;
      end
    end
  end

  function automatic logic [15:0] eff_addr();
    return {addr_hi, (m_nm ? addr_lo : latch_lo)};
  endfunction

  always @(posedge clk) begin
    if (ale) latch_lo = ad_out;
    if (!wr_n) sram[int'(eff_addr())] = ad_out;
  end

  always @(negedge clk) begin
    if (!rd_n) ad_in = sram.exists(int'(eff_addr())) ? sram[int'(eff_addr())] : dflt(eff_addr());
    else       ad_in = 8'h5A;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      int  a;
      bit  e_ale, dph, strb, e_oe;
      logic [7:0] e_ad;
      a     = alen(m_nm);
      e_ale = m_busy && !m_nm && (m_t < a);
      dph   = m_busy && (m_t >= a);
      strb  = m_busy && (m_t >= a + 1) && (m_t < a + 1 + STB_N);
      e_oe  = e_ale || (dph && m_we);
      e_ad  = e_ale ? m_addr[7:0] : ((dph && m_we) ? m_wd : 8'h00);
      chk("R1/R3/R10/R11 ale", {15'b0, ale}, {15'b0, e_ale});
      chk("R2/R9/R11 addr_hi", {8'b0, addr_hi}, {8'b0, (m_busy ? m_addr[15:8] : 8'h00)});
      chk("R1/R10/R11 addr_lo", {8'b0, addr_lo}, {8'b0, ((m_busy && m_nm) ? m_addr[7:0] : 8'h00)});
      chk("R3/R4/R5/R11 ad_oe", {15'b0, ad_oe}, {15'b0, e_oe});
      chk("R3/R4/R5/R10 ad_out", {8'b0, ad_out}, {8'b0, e_ad});
      chk("R6/R11 rd_n", {15'b0, rd_n}, {15'b0, !(strb && !m_we)});
      chk("R6/R11 wr_n", {15'b0, wr_n}, {15'b0, !(strb && m_we)});
      chk("R8/R9 done", {15'b0, done}, {15'b0, m_done});
      chk("R7/R11 rdata", {8'b0, rdata}, {8'b0, m_rdata});
    end
  end

  task automatic access(bit w, bit nm, logic [15:0] a, logic [7:0] d);
    while (m_busy) @(negedge clk);
    req = 1; we = w; nonmux_sel = nm; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; nonmux_sel = 0; addr = 16'hDEAD; wdata = 8'hEE;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; req = 0; we = 0; nonmux_sel = 0; addr = '0; wdata = '0; ad_in = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    chk_on = 1;                  // R11: idle outputs checked during reset
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);   // R11: idle after release

    // R3 R5 R6: multiplexed writes
    access(1, 0, 16'h12A4, 8'h5E);
    access(1, 0, 16'hFF00, 8'h81);
    // R4 R7: multiplexed reads, one of an unwritten address
    access(0, 0, 16'h12A4, 8'h00);
    access(0, 0, 16'hFF00, 8'h00);
    access(0, 0, 16'h0707, 8'h00);

    // R10 R1: non-multiplexed write, reads across modes
    access(1, 1, 16'h3C01, 8'hE7);
    access(0, 1, 16'h3C01, 8'h00);
    access(0, 1, 16'h12A4, 8'h00);
    access(0, 0, 16'h3C01, 8'h00);

    // mixed patterns
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ad;
      ad = 16'h1357 * i[15:0] + 16'h0F0F;
      access(1, i[0], ad, 8'hA0 ^ i[7:0]);
      access(0, i[1], ad, 8'h00);
    end

    // R9: junk requests during a busy access are ignored
    access(0, 1, 16'h4455, 8'h00);
    req = 1; we = 1; nonmux_sel = 0; addr = 16'hBEEF; wdata = 8'h99;
    repeat (2) @(negedge clk);
    req = 0;
    access(1, 0, 16'h6677, 8'h42);
    req = 1; we = 0; nonmux_sel = 1; addr = 16'h0001; wdata = 8'h11;
    repeat (3) @(negedge clk);
    req = 0;
    access(0, 0, 16'hBEEF, 8'h00);

    // R9: request held high, accepted in each done cycle
    while (m_busy) @(negedge clk);
    req = 1; we = 0; nonmux_sel = 0; addr = 16'h6677; wdata = 8'h00;
    repeat (24) @(negedge clk);
    req = 0;

    while (m_busy || m_done) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule